// File: doc/BRIEF.md
# USB Host Transmit Endpoint Control and Status

This block holds the byte-wide control and status word for one transmit endpoint of a USB host controller and updates it from link events. Software reads and writes the word through a small byte bus with address decode. The packet engine side reports handshakes, the endpoint's transfer type, frame ticks, packet completion and retry exhaustion. The block drives the data-toggle clear, a FIFO flush strobe, a DMA abort strobe, the transmit-ready flag, the setup-packet flag and a halt indication.

Three flags are sticky: the NAK-timeout halt, the stall flag and the error flag. Hardware sets them. They stay set until software writes a 0 to that bit. A received STALL handshake stops DMA, flushes the FIFO and drops transmit-ready with no help from software. A frame counter enforces a NAK limit on bulk endpoints only.

Top module: `txep_ctl_status`

## Requirements
- R1: After reset the word reads 0x00 (with the FIFO-not-empty input low), and every strobe, transmit-ready and halt output is low.
- R2: The word is read combinationally when `bus_addr` equals `REG_ADDR`. Its bits are: 7 NAK-timeout halt, 6 toggle-clear command, 5 stall, 4 setup, 3 flush command, 2 error, 1 FIFO-not-empty, 0 transmit-ready. Any other address reads 0x00, and writes to any other address change nothing.
- R3: A STALL handshake sets bit 5 at the next edge. At that same edge it clears bit 0, and `fifo_flush_o` and `dma_abort_o` each pulse high for one cycle. The hardware clear of bit 0 wins over a software set in the same cycle.
- R4: For bits 7, 5 and 2, writing 1 has no effect and writing 0 clears the bit. When a hardware set and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R5: On a bulk endpoint with a nonzero limit N, a NAK handshake starts a count of frame ticks. On the N-th tick with no other handshake in between, bit 7 sets at that edge. With N = 1, the first tick after the NAK sets it.
- R6: Bit 7 never sets while the endpoint is not bulk, or while the NAK limit is zero.
- R7: Any non-NAK handshake (`hs_other` or `hs_stall`) restarts the NAK tick count, so a later timeout needs a fresh NAK and N more ticks.
- R8: `ep_halt_o` is high exactly while bit 7 or bit 5 is set.
- R9: A write with bit 6 high gives a one-cycle `toggle_clr_o` pulse in the following cycle. Bit 6 always reads 0.
- R10: A write with bit 3 high gives a one-cycle `fifo_flush_o` pulse in the following cycle, without `dma_abort_o`. Bit 3 always reads 0.
- R11: Bit 0 takes the written value on each write and drives `tx_ready_o`. `pkt_sent` clears it at the next edge, and this clear wins over a same-cycle write.
- R12: `retry_exhausted` sets bit 2 at the next edge.
- R13: Bit 1 follows `fifo_not_empty` combinationally, and writes to it are ignored. Bit 4 stores the written value and drives `setup_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| hs_nak | input | 1 | NAK handshake received |
| hs_stall | input | 1 | STALL handshake received |
| hs_other | input | 1 | Any other handshake received |
| ep_bulk | input | 1 | Endpoint is a bulk endpoint |
| frame_tick | input | 1 | One pulse per frame |
| nak_limit | input | LIM_W | NAK timeout in frames; 0 disables |
| pkt_sent | input | 1 | Packet transmitted |
| retry_exhausted | input | 1 | Packet engine gave up on retries |
| fifo_not_empty | input | 1 | Transmit FIFO holds data |
| toggle_clr_o | output | 1 | Clear the data toggle (one-cycle pulse) |
| fifo_flush_o | output | 1 | Flush the transmit FIFO (one-cycle pulse) |
| dma_abort_o | output | 1 | Abort the DMA request (one-cycle pulse) |
| tx_ready_o | output | 1 | Packet is ready to send |
| setup_o | output | 1 | Packet is a setup packet |
| ep_halt_o | output | 1 | Endpoint halted |

## Verification
The bench drives a STALL in the same cycle as a software write that sets transmit-ready. A design that let software win would leave a halted endpoint claiming a packet was ready. It drives a software clear and a hardware set of the error flag together, and a design with the wrong priority would lose the error. It restarts the NAK count partway with an ACK-type handshake, uses a NAK limit of one, and repeats the sequence on a non-bulk endpoint and with a zero limit. An off-by-one counter or a missing transfer-type gate would halt the endpoint one frame early or late, or halt an endpoint that should never time out. It also writes 1 to sticky bits and to a foreign address, where a careless decode would clear flags or corrupt the word.

// File: rtl/txep_pkg.sv
package txep_pkg;
   // Bit positions inside the control/status byte; software decodes these.
   localparam int B_NAK   = 7;
   localparam int B_TOG   = 6;
   localparam int B_STALL = 5;
   localparam int B_SETUP = 4;
   localparam int B_FLUSH = 3;
   localparam int B_ERR   = 2;
   localparam int B_FNE   = 1;
   localparam int B_RDY   = 0;

   // Sticky flag slots.
   localparam int N_STICKY = 3;
   localparam int S_NAK    = 0;
   localparam int S_STALL  = 1;
   localparam int S_ERR    = 2;

   typedef struct packed {
      logic                hit;
      logic [N_STICKY-1:0] clr;
      logic                setup_v;
      logic                rdy_v;
      logic                tog;
      logic                flush;
   } sw_cmd_t;
endpackage

// File: rtl/txep_bus_decode.sv
module txep_bus_decode
   import txep_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wdata,
   output sw_cmd_t           cmd,
   output logic              rd_sel
);
   localparam logic [ADDR_W-1:0] MY_ADDR = REG_ADDR[ADDR_W-1:0];

   logic unused_fne;
   assign unused_fne = wdata[B_FNE];

   always_comb begin
      rd_sel         = (addr == MY_ADDR);
      cmd.hit        = wr_en && rd_sel;
      cmd.clr[S_NAK]   = cmd.hit && !wdata[B_NAK];
      cmd.clr[S_STALL] = cmd.hit && !wdata[B_STALL];
      cmd.clr[S_ERR]   = cmd.hit && !wdata[B_ERR];
      cmd.setup_v    = wdata[B_SETUP];
      cmd.rdy_v      = wdata[B_RDY];
      cmd.tog        = cmd.hit && wdata[B_TOG];
      cmd.flush      = cmd.hit && wdata[B_FLUSH];
   end
endmodule

// File: rtl/txep_sticky_bit.sv
module txep_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (hw_set) q <= 1'b1;
      else if (sw_clr) q <= 1'b0;
   end

   // R4
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !sw_clr) |=> q);
   // R4
   hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> q);
endmodule

// File: rtl/txep_nak_timer.sv
module txep_nak_timer #(
   parameter int LIM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ep_bulk,
   input  logic [LIM_W-1:0] nak_limit,
   input  logic             hs_nak,
   input  logic             restart,
   input  logic             frame_tick,
   output logic             timeout
);
   logic             active;
   logic [LIM_W-1:0] cnt;
   logic [LIM_W:0]   cnt_nx;
   logic             lim_on;

   always_comb begin
      lim_on  = (nak_limit != '0);
      cnt_nx  = {1'b0, cnt} + 1'b1;
      timeout = frame_tick && active && ep_bulk && lim_on
                && (cnt_nx >= {1'b0, nak_limit});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (restart || timeout || !ep_bulk || !lim_on) begin
         active <= 1'b0;
         cnt    <= '0;
      end else begin
         if (hs_nak)              active <= 1'b1;
         if (frame_tick && active) cnt   <= cnt_nx[LIM_W-1:0];
      end
   end

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $stable(nak_limit)) |-> (cnt < nak_limit));
   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0) && !active);
endmodule

// File: rtl/txep_ctl_status.sv
module txep_ctl_status
   import txep_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 2,
   parameter int LIM_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              hs_nak,
   input  logic              hs_stall,
   input  logic              hs_other,
   input  logic              ep_bulk,
   input  logic              frame_tick,
   input  logic [LIM_W-1:0]  nak_limit,
   input  logic              pkt_sent,
   input  logic              retry_exhausted,
   input  logic              fifo_not_empty,
   output logic              toggle_clr_o,
   output logic              fifo_flush_o,
   output logic              dma_abort_o,
   output logic              tx_ready_o,
   output logic              setup_o,
   output logic              ep_halt_o
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (REG_ADDR >= 0 && REG_ADDR < ADDR_SPAN) else $error("REG_ADDR outside address space");
      assert (LIM_W >= 1 && LIM_W <= 16) else $error("LIM_W out of range");
   end

   sw_cmd_t             cmd;
   logic                rd_sel;
   logic                nak_timeout;
   logic [N_STICKY-1:0] hw_set;
   logic [N_STICKY-1:0] flag_q;
   logic                rdy_q;
   logic                setup_q;

   txep_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
      .addr   (bus_addr),
      .wr_en  (bus_wr),
      .wdata  (bus_wdata),
      .cmd    (cmd),
      .rd_sel (rd_sel)
   );

   txep_nak_timer #(.LIM_W(LIM_W)) u_nak (
      .clk        (clk),
      .rst_n      (rst_n),
      .ep_bulk    (ep_bulk),
      .nak_limit  (nak_limit),
      .hs_nak     (hs_nak),
      .restart    (hs_other || hs_stall),
      .frame_tick (frame_tick),
      .timeout    (nak_timeout)
   );

   always_comb begin
      hw_set[S_NAK]   = nak_timeout;
      hw_set[S_STALL] = hs_stall;
      hw_set[S_ERR]   = retry_exhausted;
   end

   for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
      txep_sticky_bit u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .hw_set (hw_set[i]),
         .sw_clr (cmd.clr[i]),
         .q      (flag_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q        <= 1'b0;
         setup_q      <= 1'b0;
         toggle_clr_o <= 1'b0;
         fifo_flush_o <= 1'b0;
         dma_abort_o  <= 1'b0;
      end else begin
         if (hs_stall || pkt_sent) rdy_q <= 1'b0;
         else if (cmd.hit)         rdy_q <= cmd.rdy_v;
         if (cmd.hit) setup_q <= cmd.setup_v;
         toggle_clr_o <= cmd.tog;
         fifo_flush_o <= cmd.flush || hs_stall;
         dma_abort_o  <= hs_stall;
      end
   end

   always_comb begin
      tx_ready_o = rdy_q;
      setup_o    = setup_q;
      ep_halt_o  = flag_q[S_NAK] || flag_q[S_STALL];
      bus_rdata  = '0;
      if (rd_sel) begin
         bus_rdata[B_NAK]   = flag_q[S_NAK];
         bus_rdata[B_STALL] = flag_q[S_STALL];
         bus_rdata[B_SETUP] = setup_q;
         bus_rdata[B_ERR]   = flag_q[S_ERR];
         bus_rdata[B_FNE]   = fifo_not_empty;
         bus_rdata[B_RDY]   = rdy_q;
      end
   end

   // R3
   stall_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_stall |=> (flag_q[S_STALL] && !tx_ready_o && fifo_flush_o && dma_abort_o));
   // R9
   toggle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      toggle_clr_o |-> $past(bus_wr && rd_sel && bus_wdata[B_TOG]));
   // R10
   abort_has_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_abort_o |-> fifo_flush_o);
   // R11
   sent_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_sent |=> !tx_ready_o);
   // R8
   halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_halt_o) |-> $past(hs_stall || nak_timeout));
endmodule

// File: tb/sim_txep_ctl_status.sv
module sim_txep_ctl_status;
   localparam int ADDR_W = 4;
   localparam int REG_A  = 2;
   localparam int LIM_W  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = REG_A[ADDR_W-1:0];
   logic              bus_wr = 1'b0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;
   logic hs_nak = 0, hs_stall = 0, hs_other = 0, ep_bulk = 1, frame_tick = 0;
   logic [LIM_W-1:0]  nak_limit = 5'd3;
   logic pkt_sent = 0, retry_exhausted = 0, fifo_not_empty = 0;
   logic toggle_clr_o, fifo_flush_o, dma_abort_o, tx_ready_o, setup_o, ep_halt_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   txep_ctl_status #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A), .LIM_W(LIM_W)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hs_nak(hs_nak),
      .hs_stall(hs_stall), .hs_other(hs_other), .ep_bulk(ep_bulk),
      .frame_tick(frame_tick), .nak_limit(nak_limit), .pkt_sent(pkt_sent),
      .retry_exhausted(retry_exhausted), .fifo_not_empty(fifo_not_empty),
      .toggle_clr_o(toggle_clr_o), .fifo_flush_o(fifo_flush_o),
      .dma_abort_o(dma_abort_o), .tx_ready_o(tx_ready_o), .setup_o(setup_o),
      .ep_halt_o(ep_halt_o)
   );

   // wr, wdata, {nak,stall,other,tick,sent,retry}, exp read, exp {tog,flush,abort,halt}, req
   typedef struct packed {
      logic       wr;
      logic [7:0] wd;
      logic       nak, stall, oth, tick, sent, retry;
      logic [7:0] rd;
      logic [3:0] outs;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      {1'b0, 8'h00, 6'b000000, 8'h00, 4'b0000, 4'd1},   // R1 idle
      {1'b1, 8'h01, 6'b000000, 8'h01, 4'b0000, 4'd11},  // R11 set ready
      {1'b1, 8'h11, 6'b000000, 8'h11, 4'b0000, 4'd13},  // R13 setup stored
      {1'b0, 8'h00, 6'b000010, 8'h10, 4'b0000, 4'd11},  // R11 sent clears ready
      {1'b1, 8'h11, 6'b010000, 8'h30, 4'b0111, 4'd3},   // R3 stall beats write
      {1'b1, 8'h31, 6'b000000, 8'h31, 4'b0001, 4'd4},   // R4 write 1 keeps stall
      {1'b1, 8'h00, 6'b000000, 8'h00, 4'b0000, 4'd8},   // R8 clear stall
      {1'b1, 8'h40, 6'b000000, 8'h00, 4'b1000, 4'd9},   // R9 toggle pulse
      {1'b1, 8'h08, 6'b000000, 8'h00, 4'b0100, 4'd10},  // R10 flush pulse
      {1'b0, 8'h00, 6'b000001, 8'h04, 4'b0000, 4'd12},  // R12 error set
      {1'b1, 8'h04, 6'b000000, 8'h04, 4'b0000, 4'd4},   // R4 write 1 keeps error
      {1'b1, 8'h00, 6'b000001, 8'h04, 4'b0000, 4'd4},   // R4 hw set wins
      {1'b1, 8'h00, 6'b000000, 8'h00, 4'b0000, 4'd4},   // R4 clear error
      {1'b0, 8'h00, 6'b100000, 8'h00, 4'b0000, 4'd5},   // R5 nak
      {1'b0, 8'h00, 6'b000100, 8'h00, 4'b0000, 4'd5},   // R5 tick 1
      {1'b0, 8'h00, 6'b000100, 8'h00, 4'b0000, 4'd5},   // R5 tick 2
      {1'b0, 8'h00, 6'b001000, 8'h00, 4'b0000, 4'd7},   // R7 restart
      {1'b0, 8'h00, 6'b100000, 8'h00, 4'b0000, 4'd7},   // R7 nak again
      {1'b0, 8'h00, 6'b000100, 8'h00, 4'b0000, 4'd7},   // R7 no early timeout
      {1'b0, 8'h00, 6'b000100, 8'h00, 4'b0000, 4'd7},   // R7 tick 2
      {1'b0, 8'h00, 6'b000100, 8'h80, 4'b0001, 4'd5},   // R5 timeout on 3rd
      {1'b1, 8'h80, 6'b000000, 8'h80, 4'b0001, 4'd4},   // R4 write 1 keeps halt
      {1'b1, 8'h00, 6'b000000, 8'h00, 4'b0000, 4'd8}    // R8 halt released
   };

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic clear_in();
      bus_wr = 0; bus_wdata = '0; hs_nak = 0; hs_stall = 0; hs_other = 0;
      frame_tick = 0; pkt_sent = 0; retry_exhausted = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #2;
      // R1 reset state
      check8("R1 read after reset", bus_rdata, 8'h00);
      check8("R1 outputs after reset",
             {2'b00, toggle_clr_o, fifo_flush_o, dma_abort_o, tx_ready_o, setup_o, ep_halt_o},
             8'h00);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < NV; i++) begin
         bus_wr = VEC[i].wr; bus_wdata = VEC[i].wd;
         {hs_nak, hs_stall, hs_other, frame_tick, pkt_sent, retry_exhausted} =
            {VEC[i].nak, VEC[i].stall, VEC[i].oth, VEC[i].tick, VEC[i].sent, VEC[i].retry};
         step();
         check8($sformatf("R%0d row %0d read", VEC[i].req, i), bus_rdata, VEC[i].rd);
         check8($sformatf("R%0d row %0d strobes", VEC[i].req, i),
                {4'h0, toggle_clr_o, fifo_flush_o, dma_abort_o, ep_halt_o},
                {4'h0, VEC[i].outs});
      end
      clear_in();
      step();
      check8("R9 R10 strobes drop", {5'd0, toggle_clr_o, fifo_flush_o, dma_abort_o}, 8'h00);

      // R6 non-bulk never times out
      ep_bulk = 0;
      hs_nak = 1; step(); hs_nak = 0;
      for (int k = 0; k < 6; k++) begin frame_tick = 1; step(); end
      frame_tick = 0;
      check8("R6 non-bulk", bus_rdata, 8'h00);
      // R6 zero limit disables
      ep_bulk = 1; nak_limit = '0;
      hs_nak = 1; step(); hs_nak = 0;
      for (int k = 0; k < 6; k++) begin frame_tick = 1; step(); end
      frame_tick = 0;
      check8("R6 zero limit", bus_rdata, 8'h00);
      // R5 limit of one
      nak_limit = 5'd1;
      hs_nak = 1; step(); hs_nak = 0;
      frame_tick = 1; step(); frame_tick = 0;
      check8("R5 limit one", bus_rdata, 8'h80);
      check8("R8 halt high", {7'd0, ep_halt_o}, 8'h01);
      bus_wr = 1; bus_wdata = 8'h00; step(); bus_wr = 0;
      check8("R4 halt cleared", bus_rdata, 8'h00);

      // R13 read-only FIFO bit and setup output
      fifo_not_empty = 1; #1;
      check8("R13 fifo bit live", bus_rdata, 8'h02);
      bus_wr = 1; bus_wdata = 8'h10; step(); bus_wr = 0;
      check8("R13 setup and fifo", bus_rdata, 8'h12);
      check8("R13 setup_o", {7'd0, setup_o}, 8'h01);
      fifo_not_empty = 0; #1;
      check8("R13 fifo bit follows", bus_rdata, 8'h10);

      // R2 foreign address
      bus_addr = 4'h5; #1;
      check8("R2 other address reads zero", bus_rdata, 8'h00);
      bus_wr = 1; bus_wdata = 8'h01; step(); bus_wr = 0;
      bus_addr = REG_A[ADDR_W-1:0]; #1;
      check8("R2 foreign write ignored", bus_rdata, 8'h10);
      check8("R11 ready output", {7'd0, tx_ready_o}, 8'h00);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule